// File: doc/BRIEF.md
# Effective Address Bank Resolver

This block forms the 24-bit effective address of a data access or an indirect jump for a 16-bit CPU whose memory is split into 64 KiB banks. It holds two pieces of state: a data bank register of 8 bits and a direct page register of 16 bits. Each cycle it combines the current addressing-mode code, the instruction operand, the index value, the stack pointer, the program bank and those two registers. The result is one final access address and, for indirect modes, the address from which a pointer must be fetched first.

The upper byte of each address comes from a different source in each mode. It can be the operand itself, the data bank register, bank zero or the program bank. The offset part either wraps inside its bank or, for absolute indexed accesses, carries into the bank byte. The caller fetches the pointer at the pointer address and presents the bytes it read on the pointer-data input. The final address for that mode is then available in the same cycle.

The two registers are loaded through plain write ports, as a pull from the stack would load them. They are read back through their own outputs for a push. A value written in one cycle is used from the next cycle on. The address outputs are combinational from the inputs and the registered state.

Top module: `ea_bank_resolver`

## Requirements
- R1: Mode code 0 (long): the final address equals the 24-bit operand unchanged, and no pointer fetch is flagged.
- R2: Mode code 1 (absolute): the final address is the data bank register in bits 23:16 with operand bits 15:0 below it. Mode code 2 (absolute indexed): that same 24-bit value plus the 16-bit index, modulo 2^24, so a carry out of the offset raises the bank byte.
- R3: Mode code 3 (direct page) gives bank zero with offset (direct page register + operand bits 7:0) mod 2^16. Mode code 4 (direct page indexed) adds the index to that sum, still mod 2^16. Mode code 5 (stack relative) gives bank zero with offset (stack pointer + operand bits 7:0) mod 2^16.
- R4: Mode code 6 (direct indirect) flags a pointer fetch at bank zero, offset (direct page register + operand bits 7:0) mod 2^16. The final address is the data bank register in bits 23:16 with pointer-data bits 15:0 below it.
- R5: Mode code 7 (direct indirect long) flags a pointer fetch at the same address as R4. The final address is the 24-bit pointer data unchanged.
- R6: Mode code 8 (jump indirect) and mode code 9 (jump indirect long) flag a pointer fetch at bank zero with operand bits 15:0 as the offset. Mode 8 yields the program bank with pointer-data bits 15:0. Mode 9 yields the 24-bit pointer data.
- R7: Mode code 10 (jump indexed indirect) flags a pointer fetch at the program bank with offset (operand bits 15:0 + index) mod 2^16. The final address is the program bank with pointer-data bits 15:0.
- R8: When a register's write enable is high at a rising clock edge, that register takes the write data, and its read-back output shows the new value from that edge on. The address outputs in the cycle of the write still use the old value. With its write enable low, the register holds its value.
- R9: While the active-low reset is low, both registers are cleared to zero at the clock edge, and any write request is ignored.
- R10: In every mode that fetches no pointer, the pointer address output is zero and the fetch flag is low. Mode codes 11 to 15 are unused: they drive both addresses to zero and the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 4 | Addressing-mode code (see requirements) |
| operand | input | 24 | Operand bytes, low byte in bits 7:0 |
| index | input | 16 | Index register value |
| sp | input | 16 | Stack pointer |
| pbr | input | 8 | Program bank |
| ptr_data | input | 24 | Pointer bytes fetched from the pointer address |
| dbr_wr_en | input | 1 | Load the data bank register |
| dbr_wr_data | input | 8 | Value for the data bank register |
| dpr_wr_en | input | 1 | Load the direct page register |
| dpr_wr_data | input | 16 | Value for the direct page register |
| dbr_q | output | 8 | Current data bank register |
| dpr_q | output | 16 | Current direct page register |
| ptr_need | output | 1 | A pointer fetch is needed for this mode |
| ptr_addr | output | 24 | Address of the pointer fetch |
| eff_addr | output | 24 | Final access or jump-target address |

## Verification
The assertions assume that the mode, operand, index, stack pointer, program bank, pointer data and write inputs are stable around each rising edge and hold known values while reset is released. The properties on pointer modes also assume that the pointer data presented belongs to the current cycle. The stimulus changes all inputs only on falling edges and draws every code, including the unused ones, with random operands. It mixes random register writes with each mode, so that a write issued in the same cycle as an access tests the one-cycle delay.

// File: rtl/ea_pkg.sv
// Package: shared mode codes and mode classification for the address resolver.
// Assumes a 4-bit mode code; codes above the last listed value are unused.
package ea_pkg;

    typedef enum logic [3:0] {
        AM_LONG      = 4'd0,
        AM_ABS       = 4'd1,
        AM_ABS_X     = 4'd2,
        AM_DP        = 4'd3,
        AM_DP_X      = 4'd4,
        AM_STK       = 4'd5,
        AM_DP_IND    = 4'd6,
        AM_DP_IND_L  = 4'd7,
        AM_JMP_IND   = 4'd8,
        AM_JMP_IND_L = 4'd9,
        AM_JMP_IND_X = 4'd10
    } am_e;

    localparam int MODE_W = 4;

    // True for modes whose final address depends on a fetched pointer.
    function automatic logic needs_pointer(input logic [MODE_W-1:0] m);
        return (m == AM_DP_IND)  || (m == AM_DP_IND_L) ||
               (m == AM_JMP_IND) || (m == AM_JMP_IND_L) ||
               (m == AM_JMP_IND_X);
    endfunction

endpackage

// File: rtl/ea_bank_regs.sv
// Module: holds the data bank and direct page registers.
// Assumes synchronous active-low reset that overrides any write request.
// A write lands at the clock edge, so readers see it from the next cycle.
module ea_bank_regs #(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbr_we,
    input  logic [BANK_W-1:0] dbr_wd,
    input  logic              dpr_we,
    input  logic [OFS_W-1:0]  dpr_wd,
    output logic [BANK_W-1:0] dbr,
    output logic [OFS_W-1:0]  dpr
);

    // Data bank register: cleared by reset, loaded on write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbr <= '0;
        end else if (dbr_we) begin
            dbr <= dbr_wd;
        end
    end

    // Direct page register: cleared by reset, loaded on write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dpr <= '0;
        end else if (dpr_we) begin
            dpr <= dpr_wd;
        end
    end

endmodule

// File: rtl/ea_ptr_gen.sv
// Module: computes the pointer-fetch address and the fetch flag.
// Assumes the operand low byte is the direct page offset and bits 15:0
// are the absolute offset. Offsets wrap within their bank.
module ea_ptr_gen
    import ea_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    localparam int ADDR_W = BANK_W + OFS_W
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] operand,
    input  logic [OFS_W-1:0]  index,
    input  logic [BANK_W-1:0] pbr,
    input  logic [OFS_W-1:0]  dpr,
    output logic              ptr_need,
    output logic [ADDR_W-1:0] ptr_addr
);

    localparam int DPO_W = 8;

    logic [OFS_W-1:0] dp_ofs;
    logic [OFS_W-1:0] absx_ofs;

    // Bank-local offsets for the direct page and indexed pointer forms.
    always_comb begin
        dp_ofs   = dpr + {{(OFS_W-DPO_W){1'b0}}, operand[DPO_W-1:0]};
        absx_ofs = operand[OFS_W-1:0] + index;
    end

    // Select the pointer bank and offset by mode.
    always_comb begin
        ptr_need = needs_pointer(mode);
        unique case (mode)
            AM_DP_IND, AM_DP_IND_L:   ptr_addr = {{BANK_W{1'b0}}, dp_ofs};
            AM_JMP_IND, AM_JMP_IND_L: ptr_addr = {{BANK_W{1'b0}}, operand[OFS_W-1:0]};
            AM_JMP_IND_X:             ptr_addr = {pbr, absx_ofs};
            default:                  ptr_addr = '0;
        endcase
    end

endmodule

// File: rtl/ea_final_gen.sv
// Module: computes the final access or jump-target address.
// Assumes ptr_data already holds the pointer fetched at the pointer address.
// Bank-zero offsets wrap at 2^OFS_W; absolute indexed carries into the bank.
module ea_final_gen
    import ea_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    localparam int ADDR_W = BANK_W + OFS_W
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] operand,
    input  logic [OFS_W-1:0]  index,
    input  logic [OFS_W-1:0]  sp,
    input  logic [BANK_W-1:0] pbr,
    input  logic [BANK_W-1:0] dbr,
    input  logic [OFS_W-1:0]  dpr,
    input  logic [ADDR_W-1:0] ptr_data,
    output logic [ADDR_W-1:0] eff_addr
);

    localparam int DPO_W = 8;

    logic [OFS_W-1:0]  dp_ofs;
    logic [OFS_W-1:0]  dpx_ofs;
    logic [OFS_W-1:0]  stk_ofs;
    logic [ADDR_W-1:0] abs_full;
    logic [ADDR_W-1:0] absx_full;

    // Offsets and full-width sums used by the data modes.
    always_comb begin
        dp_ofs    = dpr + {{(OFS_W-DPO_W){1'b0}}, operand[DPO_W-1:0]};
        dpx_ofs   = dp_ofs + index;
        stk_ofs   = sp + {{(OFS_W-DPO_W){1'b0}}, operand[DPO_W-1:0]};
        abs_full  = {dbr, operand[OFS_W-1:0]};
        absx_full = abs_full + {{BANK_W{1'b0}}, index};
    end

    // Pick the bank source and offset by mode.
    always_comb begin
        unique case (mode)
            AM_LONG:      eff_addr = operand;
            AM_ABS:       eff_addr = abs_full;
            AM_ABS_X:     eff_addr = absx_full;
            AM_DP:        eff_addr = {{BANK_W{1'b0}}, dp_ofs};
            AM_DP_X:      eff_addr = {{BANK_W{1'b0}}, dpx_ofs};
            AM_STK:       eff_addr = {{BANK_W{1'b0}}, stk_ofs};
            AM_DP_IND:    eff_addr = {dbr, ptr_data[OFS_W-1:0]};
            AM_DP_IND_L:  eff_addr = ptr_data;
            AM_JMP_IND:   eff_addr = {pbr, ptr_data[OFS_W-1:0]};
            AM_JMP_IND_L: eff_addr = ptr_data;
            AM_JMP_IND_X: eff_addr = {pbr, ptr_data[OFS_W-1:0]};
            default:      eff_addr = '0;
        endcase
    end

endmodule

// File: rtl/ea_bank_resolver.sv
// Module: top of the effective address bank resolver.
// Holds the bank and direct page registers and forms the pointer and final
// addresses combinationally from the mode, the operands and the register state.
// Assumes the caller feeds the fetched pointer back on ptr_data in the same cycle.
module ea_bank_resolver
    import ea_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    localparam int ADDR_W = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] operand,
    input  logic [OFS_W-1:0]  index,
    input  logic [OFS_W-1:0]  sp,
    input  logic [BANK_W-1:0] pbr,
    input  logic [ADDR_W-1:0] ptr_data,
    input  logic              dbr_wr_en,
    input  logic [BANK_W-1:0] dbr_wr_data,
    input  logic              dpr_wr_en,
    input  logic [OFS_W-1:0]  dpr_wr_data,
    output logic [BANK_W-1:0] dbr_q,
    output logic [OFS_W-1:0]  dpr_q,
    output logic              ptr_need,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [BANK_W-1:0] dbr;
    logic [OFS_W-1:0]  dpr;

    ea_bank_regs #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .dbr_we (dbr_wr_en),
        .dbr_wd (dbr_wr_data),
        .dpr_we (dpr_wr_en),
        .dpr_wd (dpr_wr_data),
        .dbr    (dbr),
        .dpr    (dpr)
    );

    ea_ptr_gen #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_ptr (
        .mode     (mode),
        .operand  (operand),
        .index    (index),
        .pbr      (pbr),
        .dpr      (dpr),
        .ptr_need (ptr_need),
        .ptr_addr (ptr_addr)
    );

    ea_final_gen #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_final (
        .mode     (mode),
        .operand  (operand),
        .index    (index),
        .sp       (sp),
        .pbr      (pbr),
        .dbr      (dbr),
        .dpr      (dpr),
        .ptr_data (ptr_data),
        .eff_addr (eff_addr)
    );

    // Register read-back for pushes.
    always_comb begin
        dbr_q = dbr;
        dpr_q = dpr;
    end

endmodule

// File: rtl/ea_bank_resolver_chk.sv
// Module: assertion checker for the resolver, attached by bind below.
// Assumes inputs change only away from the rising clock edge.
module ea_bank_resolver_chk
    import ea_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    localparam int ADDR_W = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] operand,
    input  logic [BANK_W-1:0] pbr,
    input  logic [ADDR_W-1:0] ptr_data,
    input  logic              dbr_wr_en,
    input  logic [BANK_W-1:0] dbr_wr_data,
    input  logic              dpr_wr_en,
    input  logic [OFS_W-1:0]  dpr_wr_data,
    input  logic [BANK_W-1:0] dbr_q,
    input  logic [OFS_W-1:0]  dpr_q,
    input  logic              ptr_need,
    input  logic [ADDR_W-1:0] ptr_addr,
    input  logic [ADDR_W-1:0] eff_addr
);

    localparam int HI = ADDR_W - 1;
    localparam int LO = OFS_W;

    a_r1_long_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == AM_LONG) |-> (eff_addr == operand && !ptr_need));

    a_r2_abs_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == AM_ABS) |-> (eff_addr == {dbr_q, operand[OFS_W-1:0]}));

    a_r3_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == AM_DP || mode == AM_DP_X || mode == AM_STK) |-> (eff_addr[HI:LO] == '0));

    a_r4_dp_ind: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == AM_DP_IND) |-> (ptr_need && ptr_addr[HI:LO] == '0 &&
                                 eff_addr == {dbr_q, ptr_data[OFS_W-1:0]}));

    a_r5_dp_ind_long: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == AM_DP_IND_L) |-> (ptr_need && eff_addr == ptr_data));

    a_r7_jmp_x_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == AM_JMP_IND_X) |-> (ptr_addr[HI:LO] == pbr && eff_addr[HI:LO] == pbr));

    a_r8_dbr_load: assert property (@(posedge clk) disable iff (!rst_n)
        dbr_wr_en |=> (dbr_q == $past(dbr_wr_data)));

    a_r8_dbr_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !dbr_wr_en |=> $stable(dbr_q));

    a_r8_dpr_load: assert property (@(posedge clk) disable iff (!rst_n)
        dpr_wr_en |=> (dpr_q == $past(dpr_wr_data)));

    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (dbr_q == '0 && dpr_q == '0));

    a_r10_no_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_need |-> (ptr_addr == '0));

endmodule

bind ea_bank_resolver ea_bank_resolver_chk #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .operand     (operand),
    .pbr         (pbr),
    .ptr_data    (ptr_data),
    .dbr_wr_en   (dbr_wr_en),
    .dbr_wr_data (dbr_wr_data),
    .dpr_wr_en   (dpr_wr_en),
    .dpr_wr_data (dpr_wr_data),
    .dbr_q       (dbr_q),
    .dpr_q       (dpr_q),
    .ptr_need    (ptr_need),
    .ptr_addr    (ptr_addr),
    .eff_addr    (eff_addr)
);

// File: tb/ea_bank_resolver_bench.sv
`timescale 1ns/1ps
module ea_bank_resolver_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = '0;
    logic [23:0] operand = '0;
    logic [15:0] index = '0;
    logic [15:0] sp = '0;
    logic [7:0]  pbr = '0;
    logic [23:0] ptr_data = '0;
    logic        dbr_wr_en = 1'b0;
    logic [7:0]  dbr_wr_data = '0;
    logic        dpr_wr_en = 1'b0;
    logic [15:0] dpr_wr_data = '0;
    logic [7:0]  dbr_q;
    logic [15:0] dpr_q;
    logic        ptr_need;
    logic [23:0] ptr_addr;
    logic [23:0] eff_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Behavioural model state of the two registers.
    int m_dbr = 0;
    int m_dpr = 0;

    always #2 clk = ~clk;

    ea_bank_resolver u_ea_bank_resolver (
        .clk(clk), .rst_n(rst_n), .mode(mode), .operand(operand), .index(index),
        .sp(sp), .pbr(pbr), .ptr_data(ptr_data), .dbr_wr_en(dbr_wr_en),
        .dbr_wr_data(dbr_wr_data), .dpr_wr_en(dpr_wr_en), .dpr_wr_data(dpr_wr_data),
        .dbr_q(dbr_q), .dpr_q(dpr_q), .ptr_need(ptr_need), .ptr_addr(ptr_addr),
        .eff_addr(eff_addr)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%06h expected=%06h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int m);
        case (m)
            0: return "R1";
            1, 2: return "R2";
            3, 4, 5: return "R3";
            6: return "R4";
            7: return "R5";
            8, 9: return "R6";
            10: return "R7";
            default: return "R10";
        endcase
    endfunction

    // Reference address calculation from the requirements.
    task automatic reference(output int need, output int pa, output int ea);
        int op = int'(operand);
        int op8 = op & 'hFF;
        int op16 = op & 'hFFFF;
        int ix = int'(index);
        int pd = int'(ptr_data);
        int pb = int'(pbr);
        need = 0; pa = 0; ea = 0;
        case (int'(mode))
            0: ea = op;
            1: ea = (m_dbr << 16) | op16;
            2: ea = (((m_dbr << 16) | op16) + ix) & 'hFFFFFF;
            3: ea = (m_dpr + op8) & 'hFFFF;
            4: ea = (m_dpr + op8 + ix) & 'hFFFF;
            5: ea = (int'(sp) + op8) & 'hFFFF;
            6: begin need = 1; pa = (m_dpr + op8) & 'hFFFF; ea = (m_dbr << 16) | (pd & 'hFFFF); end
            7: begin need = 1; pa = (m_dpr + op8) & 'hFFFF; ea = pd; end
            8: begin need = 1; pa = op16; ea = (pb << 16) | (pd & 'hFFFF); end
            9: begin need = 1; pa = op16; ea = pd; end
            10: begin need = 1; pa = (pb << 16) | ((op16 + ix) & 'hFFFF); ea = (pb << 16) | (pd & 'hFFFF); end
            default: ;
        endcase
    endtask

    // Compare all outputs against the model, then let one clock edge pass.
    task automatic compare_and_clock();
        int need, pa, ea;
        string t;
        #1;
        reference(need, pa, ea);
        t = tag_of(int'(mode));
        check(t, "ptr_need", int'(ptr_need), need);
        check(t, "ptr_addr", int'(ptr_addr), pa);
        check(t, "eff_addr", int'(eff_addr), ea);
        check("R8", "dbr_q", int'(dbr_q), m_dbr);
        check("R8", "dpr_q", int'(dpr_q), m_dpr);
        @(posedge clk);
        if (rst_n) begin
            if (dbr_wr_en) m_dbr = int'(dbr_wr_data);
            if (dpr_wr_en) m_dpr = int'(dpr_wr_data);
        end else begin
            m_dbr = 0; m_dpr = 0;
        end
        @(negedge clk);
    endtask

    task automatic drive(input int m, input int op, input int ix, input int s,
                         input int pb, input int pd,
                         input bit dwe, input int dwd, input bit pwe, input int pwd);
        mode = 4'(m); operand = 24'(op); index = 16'(ix); sp = 16'(s);
        pbr = 8'(pb); ptr_data = 24'(pd);
        dbr_wr_en = dwe; dbr_wr_data = 8'(dwd);
        dpr_wr_en = pwe; dpr_wr_data = 16'(pwd);
        compare_and_clock();
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R9: reset clears registers and ignores writes during reset.
        drive(1, 'h001234, 0, 0, 0, 0, 1, 'h55, 1, 'h4321);
        drive(1, 'h001234, 0, 0, 0, 0, 1, 'h66, 1, 'h1111);
        check("R9", "dbr_q in reset", int'(dbr_q), 0);
        check("R9", "dpr_q in reset", int'(dpr_q), 0);
        rst_n = 1'b1;

        // R1: long operand passes through.
        drive(0, 'h123456, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8: write bank $AB with an absolute access in the same cycle; old bank used.
        drive(1, 'h001234, 0, 0, 0, 0, 1, 'hAB, 0, 0);
        // R2: next access reads $AB:1234.
        drive(1, 'h001234, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R2", "abs with bank AB", int'(eff_addr), 'hAB1234);
        // R2: indexed carry into bank.
        drive(0, 0, 0, 0, 0, 0, 1, 'h12, 0, 0);
        drive(2, 'h00FFFF, 2, 0, 0, 0, 0, 0, 0, 0);
        drive(2, 'h00FFFF, 'hFFFF, 0, 0, 0, 1, 'hFF, 0, 0);
        drive(2, 'h00FFFF, 'hFFFF, 0, 0, 0, 0, 0, 0, 0);
        // R3: direct page wrap within bank zero.
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 'hFFF0);
        drive(3, 'hAAAA20, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R3", "dp wrap", int'(eff_addr), 'h000010);
        drive(4, 'h000005, 'h0100, 0, 0, 0, 0, 0, 0, 0);
        drive(5, 'h0000FF, 0, 'hFFF0, 0, 0, 0, 0, 0, 0);
        // R4..R7: pointer modes.
        drive(6, 'h000012, 0, 0, 'h7E, 'h9A5678, 0, 0, 0, 0);
        drive(7, 'h000012, 0, 0, 'h7E, 'h9A5678, 0, 0, 0, 0);
        drive(8, 'hC01234, 0, 0, 'h7E, 'h9A5678, 0, 0, 0, 0);
        drive(9, 'hC01234, 0, 0, 'h7E, 'h9A5678, 0, 0, 0, 0);
        drive(10, 'h00FFFE, 4, 0, 'h7E, 'h9A5678, 0, 0, 0, 0);
        check("R7", "jmp indexed ptr wraps in bank", int'(ptr_addr), 'h7E0002);
        // R10: unused codes.
        for (int c = 11; c < 16; c++) drive(c, 'hFFFFFF, 'hFFFF, 'hFFFF, 'hFF, 'hFFFFFF, 0, 0, 0, 0);

        // Random mix of every mode with register writes.
        for (int i = 0; i < 3000; i++) begin
            drive($urandom_range(0, 15), int'($urandom) & 'hFFFFFF, int'($urandom) & 'hFFFF,
                  int'($urandom) & 'hFFFF, int'($urandom) & 'hFF, int'($urandom) & 'hFFFFFF,
                  ($urandom_range(0, 3) == 0), int'($urandom) & 'hFF,
                  ($urandom_range(0, 3) == 0), int'($urandom) & 'hFFFF);
        end

        // R9: reset mid-run clears registers again.
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 1, 'h33, 0, 0);
        rst_n = 1'b1;
        drive(1, 'h000001, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R9", "dbr after second reset", int'(dbr_q), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule